// File: doc/BRIEF.md
# Reset Strap Latch with Shared-Pin Non-Maskable Interrupt

This block controls how a processor core leaves hardware reset. While the external reset input is low, the core reset output is held low. Once the input rises, the block first passes the release through an internal synchronizer. It then holds the core in reset for a fixed number of clock edges, so the reset state can reach every part of the core. On the edge that frees the core, it latches three mode strap pins into an operating-mode register. On that same edge it latches a PLL-enable strap into a control bit.

One of the three strap pins has a second job. A fixed number of cycles after the core leaves reset, that pin stops being a mode strap and becomes a non-maskable interrupt input. Its falling edges are synchronized and detected, and each one raises a request that stays set until an acknowledge clears it. The request is always presented at priority level three, and no mask can block it. After reset, software may overwrite the operating mode through a write port.

All strap and interrupt pins pass through one shared two-stage synchronizer. The reset release passes through its own synchronizer of the same depth. Parameters: `RESET_PROP_CYCLES` (default 8, at least 1), `NMI_SWITCH_DELAY` (default 4, at least 1), `SYNC_STAGES` (default 2, at least 1).

Top module: `strap_nmi_ctrl`

## Requirements
- R1: `core_rst_n` is low while `rst_n` is low. After `rst_n` rises, `core_rst_n` rises after exactly SYNC_STAGES + RESET_PROP_CYCLES rising clock edges (10 by default). With no clock edges it stays low.
- R2: On the edge where `core_rst_n` rises, `op_mode` captures the synchronized strap levels: bit 0 from `mode_a_pin`, bit 1 from `mode_b_pin`, bit 2 from `mode_c_nmi_pin`. Each strap must be stable for at least two cycles before that edge.
- R3: `pll_en` captures the synchronized `pll_strap_pin` on that same edge. It then holds until the next hardware reset, whatever the strap does.
- R4: After capture, `op_mode` ignores changes on the strap pins.
- R5: `nmi_pin_active` rises exactly NMI_SWITCH_DELAY rising edges after the edge on which `core_rst_n` rises. It stays high until the next hardware reset.
- R6: While `nmi_pin_active` is high, a falling edge on `mode_c_nmi_pin` sets `nmi_req` on the third rising edge after the pin falls. `nmi_level` always reads 2'b11, and no input masks the request.
- R7: Rising edges and steady levels on `mode_c_nmi_pin` never set `nmi_req`.
- R8: `nmi_req` stays high until `nmi_ack` is high at a rising edge. With no new edge detected in that cycle, `nmi_req` is low after that edge.
- R9: If a falling edge is detected in the same cycle as `nmi_ack`, `nmi_req` stays high.
- R10: Falling edges on `mode_c_nmi_pin` are ignored during reset and during the switch-over window, before `nmi_pin_active` rises.
- R11: While `core_rst_n` is high, `sw_mode_we` high at a rising edge loads `sw_mode_wdata` into `op_mode`. Writes while `core_rst_n` is low are ignored.
- R12: Driving `rst_n` low asynchronously forces `core_rst_n`, `nmi_pin_active`, `nmi_req`, `pll_en` and `op_mode` to zero. This returns the shared pin to its strap role.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous |
| mode_a_pin | input | 1 | Mode strap A |
| mode_b_pin | input | 1 | Mode strap B |
| mode_c_nmi_pin | input | 1 | Mode strap C, later the NMI input (falling edge) |
| pll_strap_pin | input | 1 | PLL-enable strap |
| sw_mode_we | input | 1 | Software mode write enable |
| sw_mode_wdata | input | 3 | Software mode value |
| nmi_ack | input | 1 | Clears a pending NMI |
| core_rst_n | output | 1 | Core reset, active low |
| op_mode | output | 3 | Operating mode {C, B, A} |
| pll_en | output | 1 | PLL-enable control bit |
| nmi_pin_active | output | 1 | Shared pin is acting as the NMI input |
| nmi_req | output | 1 | Pending NMI request |
| nmi_level | output | 2 | Priority of the NMI request (always 3) |

## Verification
The acknowledge that clears a pending request and a newly detected falling edge can land on the same rising edge. The bench provokes this by dropping the shared pin and raising `nmi_ack` exactly two cycles later, which is when the synchronized edge reaches the detector. The request must still read high afterwards. A lone acknowledge is checked separately to confirm that it does clear the request, so the two outcomes are told apart.

// File: rtl/strap_nmi_pkg.sv
package strap_nmi_pkg;

  localparam int unsigned MODE_W = 3;
  localparam logic [1:0]  NMI_PRIO_LEVEL = 2'd3;

  typedef enum logic [1:0] {
    SEQ_HOLD   = 2'd0,
    SEQ_SWITCH = 2'd1,
    SEQ_RUN    = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic sel_c;
    logic sel_b;
    logic sel_a;
  } op_mode_t;

endpackage

// File: rtl/snm_sync.sv
module snm_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] stg_q;
  logic [STAGES-1:0][WIDTH-1:0] stg_d;

  if (STAGES == 1) begin : g_single
    assign stg_d = d;
  end else begin : g_chain
    assign stg_d = {stg_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stg_q <= '0;
    end else begin
      stg_q <= stg_d;
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/snm_seq.sv
module snm_seq
  import strap_nmi_pkg::*;
#(
  parameter int unsigned RESET_PROP_CYCLES = 8,
  parameter int unsigned NMI_SWITCH_DELAY  = 4
) (
  input  logic clk,
  input  logic arst_n,
  output logic core_rel,
  output logic cap_stb,
  output logic nmi_arm
);

  localparam int unsigned MAX_CNT = (RESET_PROP_CYCLES > NMI_SWITCH_DELAY) ?
                                    RESET_PROP_CYCLES : NMI_SWITCH_DELAY;
  localparam int unsigned CNT_W   = $clog2(MAX_CNT + 1);
  localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(RESET_PROP_CYCLES - 1);
  localparam logic [CNT_W-1:0] SWCH_LAST = CNT_W'(NMI_SWITCH_DELAY - 1);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             core_q, core_d;
  logic             arm_q, arm_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q + 1'b1;
    core_d  = core_q;
    arm_d   = arm_q;
    cap_stb = 1'b0;
    unique case (state_q)
      SEQ_HOLD: begin
        if (cnt_q == HOLD_LAST) begin
          state_d = SEQ_SWITCH;
          cnt_d   = '0;
          core_d  = 1'b1;
          cap_stb = 1'b1;
        end
      end
      SEQ_SWITCH: begin
        if (cnt_q == SWCH_LAST) begin
          state_d = SEQ_RUN;
          cnt_d   = '0;
          arm_d   = 1'b1;
        end
      end
      default: begin
        cnt_d = cnt_q;
      end
    endcase
  end

  assign cnt_en = (state_q != SEQ_RUN);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      state_q <= SEQ_HOLD;
      cnt_q   <= '0;
      core_q  <= 1'b0;
      arm_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      core_q  <= core_d;
      arm_q   <= arm_d;
      if (cnt_en) begin
        cnt_q <= cnt_d;
      end
    end
  end

  assign core_rel = core_q;
  assign nmi_arm  = arm_q;

endmodule

// File: rtl/snm_mode_reg.sv
module snm_mode_reg
  import strap_nmi_pkg::*;
(
  input  logic     clk,
  input  logic     arst_n,
  input  logic     cap_en,
  input  op_mode_t cap_mode,
  input  logic     cap_pll,
  input  logic     wr_en,
  input  op_mode_t wr_mode,
  output op_mode_t mode_q,
  output logic     pll_q
);

  op_mode_t mode_d;
  logic     mode_en;

  always_comb begin
    mode_en = cap_en | wr_en;
    mode_d  = cap_en ? cap_mode : wr_mode;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      mode_q <= '0;
      pll_q  <= 1'b0;
    end else begin
      if (mode_en) begin
        mode_q <= mode_d;
      end
      if (cap_en) begin
        pll_q <= cap_pll;
      end
    end
  end

endmodule

// File: rtl/snm_nmi_det.sv
module snm_nmi_det (
  input  logic clk,
  input  logic arst_n,
  input  logic armed,
  input  logic pin_s,
  input  logic ack,
  output logic req
);

  logic prev_q;
  logic req_q, req_d;
  logic fall;

  always_comb begin
    fall  = armed & prev_q & ~pin_s;
    req_d = fall | (req_q & ~ack);
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      prev_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      prev_q <= pin_s;
      req_q  <= req_d;
    end
  end

  assign req = req_q;

endmodule

// File: rtl/strap_nmi_ctrl.sv
module strap_nmi_ctrl
  import strap_nmi_pkg::*;
#(
  parameter int unsigned RESET_PROP_CYCLES = 8,
  parameter int unsigned NMI_SWITCH_DELAY  = 4,
  parameter int unsigned SYNC_STAGES       = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_a_pin,
  input  logic              mode_b_pin,
  input  logic              mode_c_nmi_pin,
  input  logic              pll_strap_pin,
  input  logic              sw_mode_we,
  input  logic [MODE_W-1:0] sw_mode_wdata,
  input  logic              nmi_ack,
  output logic              core_rst_n,
  output logic [MODE_W-1:0] op_mode,
  output logic              pll_en,
  output logic              nmi_pin_active,
  output logic              nmi_req,
  output logic [1:0]        nmi_level
);

  localparam int unsigned PIN_W = 4;

  logic             rst_q;
  logic [PIN_W-1:0] pins_raw, pins_s;
  logic             core_rel, cap_stb, nmi_arm;
  op_mode_t         cap_mode, wr_mode, mode_q;
  logic             wr_en;

  // reset release synchronizer: asserts at once, releases on the clock
  snm_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_rst_sync (
    .clk   (clk),
    .arst_n(rst_n),
    .d     (1'b1),
    .q     (rst_q)
  );

  // pin synchronizer shared by the straps and the NMI detector
  assign pins_raw = {pll_strap_pin, mode_c_nmi_pin, mode_b_pin, mode_a_pin};

  snm_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) u_pin_sync (
    .clk   (clk),
    .arst_n(rst_n),
    .d     (pins_raw),
    .q     (pins_s)
  );

  snm_seq #(
    .RESET_PROP_CYCLES(RESET_PROP_CYCLES),
    .NMI_SWITCH_DELAY (NMI_SWITCH_DELAY)
  ) u_seq (
    .clk     (clk),
    .arst_n  (rst_q),
    .core_rel(core_rel),
    .cap_stb (cap_stb),
    .nmi_arm (nmi_arm)
  );

  assign cap_mode = '{sel_c: pins_s[2], sel_b: pins_s[1], sel_a: pins_s[0]};
  assign wr_mode  = op_mode_t'(sw_mode_wdata);
  assign wr_en    = sw_mode_we & core_rel;

  snm_mode_reg u_mode (
    .clk     (clk),
    .arst_n  (rst_q),
    .cap_en  (cap_stb),
    .cap_mode(cap_mode),
    .cap_pll (pins_s[3]),
    .wr_en   (wr_en),
    .wr_mode (wr_mode),
    .mode_q  (mode_q),
    .pll_q   (pll_en)
  );

  snm_nmi_det u_nmi (
    .clk   (clk),
    .arst_n(rst_q),
    .armed (nmi_arm),
    .pin_s (pins_s[2]),
    .ack   (nmi_ack),
    .req   (nmi_req)
  );

  assign core_rst_n     = core_rel;
  assign op_mode        = mode_q;
  assign nmi_pin_active = nmi_arm;
  assign nmi_level      = NMI_PRIO_LEVEL;

endmodule

// File: rtl/strap_nmi_ctrl_chk.sv
module strap_nmi_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sw_mode_we,
  input logic [2:0] sw_mode_wdata,
  input logic       nmi_ack,
  input logic       core_rst_n,
  input logic [2:0] op_mode,
  input logic       pll_en,
  input logic       nmi_req,
  input logic       nmi_pin_active
);

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_CORE_HELD_IN_RESET: assert (!core_rst_n); // R1
      AST_NMI_CLEARED_IN_RESET: assert (!nmi_req && !nmi_pin_active); // R12
    end
  end

  AST_CORE_STAYS_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst_n |=> core_rst_n); // R1

  AST_PLL_BIT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (core_rst_n && $past(core_rst_n)) |-> $stable(pll_en)); // R3

  AST_MODE_HOLDS_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (core_rst_n && $past(core_rst_n) && !$past(sw_mode_we)) |-> $stable(op_mode)); // R4

  AST_ARM_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_pin_active |-> core_rst_n); // R5

  AST_ARM_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_pin_active |=> nmi_pin_active); // R5

  AST_NMI_HELD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_req && !nmi_ack) |=> nmi_req); // R8

  AST_NMI_ONLY_WHEN_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req |-> nmi_pin_active); // R10

  AST_SW_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (core_rst_n && sw_mode_we) |=> (op_mode == $past(sw_mode_wdata))); // R11

endmodule

bind strap_nmi_ctrl strap_nmi_ctrl_chk u_chk (.*);

// File: tb/strap_nmi_ctrl_tb.sv
module strap_nmi_ctrl_tb;

  localparam int P = 8;
  localparam int D = 4;
  localparam int S = 2;

  logic       clk = 1'b0;
  logic       clk_run = 1'b1;
  logic       rst_n;
  logic       pin_a, pin_b, pin_c, pin_pll;
  logic       we;
  logic [2:0] wdata;
  logic       ack;
  logic       core_rst_n;
  logic [2:0] op_mode;
  logic       pll_en, nmi_pin_active, nmi_req;
  logic [1:0] nmi_level;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10ns clk = clk_run ? ~clk : clk;

  strap_nmi_ctrl #(
    .RESET_PROP_CYCLES(P), .NMI_SWITCH_DELAY(D), .SYNC_STAGES(S)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_a_pin(pin_a), .mode_b_pin(pin_b),
    .mode_c_nmi_pin(pin_c), .pll_strap_pin(pin_pll), .sw_mode_we(we),
    .sw_mode_wdata(wdata), .nmi_ack(ack), .core_rst_n(core_rst_n),
    .op_mode(op_mode), .pll_en(pll_en), .nmi_pin_active(nmi_pin_active),
    .nmi_req(nmi_req), .nmi_level(nmi_level)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // release reset at a negedge, return edges until core leaves reset
  task automatic release_count(output int n);
    rst_n = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!core_rst_n && n < 100);
  endtask

  task automatic arm_count(output int m);
    m = 0;
    while (!nmi_pin_active && m < 100) begin
      @(negedge clk);
      m++;
    end
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #(20ns * 100000);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int n, m;
    rst_n = 1'b0; pin_a = 0; pin_b = 0; pin_c = 0; pin_pll = 0;
    we = 0; wdata = 0; ack = 0;
    cyc(3);
    check("R12 reset core_rst_n", core_rst_n, 0);
    check("R12 reset op_mode", op_mode, 0);
    check("R12 reset nmi_req", nmi_req, 0);
    check("R12 reset pll_en", pll_en, 0);

    // sweep every strap combination
    for (int cfg = 0; cfg < 16; cfg++) begin
      @(negedge clk);
      rst_n = 1'b0;
      {pin_pll, pin_c, pin_b, pin_a} = cfg[3:0];
      cyc(3);
      check("R1 held low in reset", core_rst_n, 0);
      release_count(n);
      check("R1 release latency", n, P + S);
      check("R2 captured mode", op_mode, cfg & 7);
      check("R3 captured pll", pll_en, (cfg >> 3) & 1);
      arm_count(m);
      check("R5 switch delay", m, D);
      pin_a = ~pin_a; pin_b = ~pin_b; pin_pll = ~pin_pll;
      cyc(5);
      check("R4 mode ignores straps", op_mode, cfg & 7);
      check("R3 pll ignores strap", pll_en, (cfg >> 3) & 1);
      check("R7 no request from steady pin", nmi_req, 0);
      check("R6 level is 3", nmi_level, 3);
    end

    // edges in reset and in the switch window are ignored
    @(negedge clk);
    rst_n = 1'b0; pin_c = 1;
    cyc(2); pin_c = 0; cyc(2); pin_c = 1; cyc(3);
    release_count(n);
    pin_c = 0;
    cyc(2);
    check("R10 window before arm", nmi_pin_active, 0);
    cyc(D + 6);
    check("R10 edges before arm ignored", nmi_req, 0);
    check("R2 mode C captured high", op_mode, 4);
    pin_c = 1;
    cyc(5);
    check("R7 rising edge ignored", nmi_req, 0);

    // falling edge latency
    pin_c = 0;
    cyc(2);
    check("R6 not yet after two edges", nmi_req, 0);
    cyc(1);
    check("R6 request on third edge", nmi_req, 1);
    cyc(5);
    check("R8 request held", nmi_req, 1);
    ack = 1; cyc(1); ack = 0;
    check("R8 ack clears", nmi_req, 0);
    cyc(3);
    check("R8 stays clear", nmi_req, 0);

    // pending again, then ack coinciding with a new edge
    pin_c = 1; cyc(4); pin_c = 0; cyc(4);
    check("R6 second request", nmi_req, 1);
    pin_c = 1; cyc(4);
    check("R7 rise keeps pending", nmi_req, 1);
    pin_c = 0;
    cyc(2); ack = 1; cyc(1); ack = 0;
    check("R9 edge with ack keeps request", nmi_req, 1);
    cyc(2);
    check("R9 still pending", nmi_req, 1);

    // software writes
    for (int v = 0; v < 8; v++) begin
      we = 1; wdata = 3'(v); cyc(1); we = 0; wdata = 3'(~v);
      check("R11 write lands", op_mode, v);
      cyc(1);
      check("R11 write holds", op_mode, v);
    end

    // asynchronous reset with a pending request
    #5ns rst_n = 1'b0;
    #2ns;
    check("R12 async core_rst_n", core_rst_n, 0);
    check("R12 async nmi_req", nmi_req, 0);
    check("R12 async pin role", nmi_pin_active, 0);
    check("R12 async op_mode", op_mode, 0);

    // no clock, no release
    @(negedge clk);
    {pin_pll, pin_c, pin_b, pin_a} = 4'b1010;
    cyc(3);
    clk_run = 1'b0;
    #5ns rst_n = 1'b1;
    #1000ns;
    check("R1 no release without clock", core_rst_n, 0);
    clk_run = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!core_rst_n && n < 100);
    check("R1 release after clock resumes", n, P + S);
    check("R2 mode after stalled clock", op_mode, 2);
    check("R3 pll after stalled clock", pll_en, 1);

    // writes during core reset are ignored
    @(negedge clk);
    rst_n = 1'b0;
    {pin_pll, pin_c, pin_b, pin_a} = 4'b0011;
    cyc(3);
    rst_n = 1'b1;
    we = 1; wdata = 3'b100;
    cyc(P);
    we = 0;
    n = P;
    while (!core_rst_n && n < 100) begin
      @(negedge clk);
      n++;
    end
    check("R11 write in reset ignored", op_mode, 3);
    check("R1 release with write held", n, P + S);

    done = 1;
    summary();
    $finish;
  end

endmodule